// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block is a two-wire bus target that behaves as a 128-byte serial EEPROM. SCL and SDA are sampled as plain inputs and brought into the system clock domain. SDA is an open-drain line: the block pulls it low by raising `sda_oe`. START, repeated START and STOP are found from edges of the synchronized lines. A control byte is decoded against a fixed device code. The block then takes a word address and optional data bytes, or it streams bytes out of its array.

An address pointer stays valid from one transaction to the next. A read with no address phase therefore returns the byte that follows the last byte accessed. A random read works as follows: a write-mode control byte and a word address load the pointer, then a repeated START and a read-mode control byte follow. Each byte the master acknowledges makes the block send the next address, and the pointer wraps at the top of the array. A NACK ends the stream.

A side port writes the array directly, so a system or a bench can preload known contents.

Top module: `eeprom_rd_target`

## Requirements
- R1: The block ACKs a control byte whose upper nibble is 4'b1010 and whose bit 0 (read/write) is 1, whatever the values of bits 3..1. It then sends the byte at the pointer, MSB first, one bit per SCL period.
- R2: The block NACKs a control byte with any other upper nibble. It then leaves SDA released until the next START, and the pointer does not change.
- R3: After a write-mode control byte (bit 0 = 0), the block ACKs the next byte and loads its low 7 bits into the pointer. A following repeated START and read control byte return the byte at that address.
- R4: A read without an address phase returns the byte at the last accessed address plus one. After reset the pointer is 0.
- R5: Each data byte the master ACKs is followed by the byte at the next address, and the address wraps from 0x7F to 0x00.
- R6: When the master NACKs a data byte, the block sends nothing more, and SDA is released after the following STOP.
- R7: Data bytes that follow the word address in a write are ACKed and stored at consecutive addresses. The pointer ends one past the last byte stored.
- R8: `sda_oe` rises only while SCL is low.
- R9: A STOP or START in the middle of a byte abandons that byte and leaves the pointer at its previous value.
- R10: While reset is held, SDA is released.
- R11: A pulse on `init_we` stores `init_data` at `init_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| init_we | input | 1 | Preload write strobe |
| init_addr | input | 7 | Preload address |
| init_data | input | 8 | Preload data |

## Verification
The array is preloaded with an address-dependent pattern, so every returned byte shows which address was read. Several patterns are run:
- Back-to-back reads with no address phase separate a pointer that advances from one that is reloaded or reset.
- A random read at a mid address separates the loaded pointer from the advancing one.
- A four-byte stream across 0x7E..0x01 exposes a wrap error or a lost increment.
- A foreign device code, written data read back, and a word address cut short by a STOP each test whether the pointer and the array stay untouched when they should.

// File: rtl/eeprom_rd_target.sv
module eeprom_rd_target #(
  parameter int ADDR_W = 7,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [7:0]        init_data
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_CTRL_ACK, S_ADDR, S_ADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_SKIP
  } state_t;

  logic [SYNC-1:0]   scl_q, sda_q;
  logic              scl_d, sda_d;
  state_t            state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] ptr;
  logic              rd_mode, mack;
  logic [7:0]        mem [DEPTH];

  wire scl_s    = scl_q[SYNC-1];
  wire sda_s    = sda_q[SYNC-1];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire byte_done = scl_fall & (bitcnt == 4'd8);
  wire bus_evt   = start_det | stop_det;
  wire dat_wr    = (state == S_WDATA) & byte_done & ~bus_evt;
  wire [7:0] rd_byte = mem[ptr];
  wire skip_st   = (state == S_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (init_we)     mem[init_addr] <= init_data;
    else if (dat_wr) mem[ptr] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state  <= S_CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_CTRL, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (state == S_CTRL) begin
              if (shreg[7:4] == DEV_CODE) begin
                rd_mode <= shreg[0];
                sda_oe  <= 1'b1;
                state   <= S_CTRL_ACK;
              end else begin
                state <= S_SKIP;
              end
            end else if (state == S_ADDR) begin
              ptr    <= shreg[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= S_ADDR_ACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= S_WDATA_ACK;
            end
          end
        end
        S_CTRL_ACK: if (scl_fall) begin
          if (rd_mode) begin
            sda_oe <= ~rd_byte[7];
            shreg  <= {rd_byte[6:0], 1'b1};
            bitcnt <= 4'd1;
            state  <= S_RDATA;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_ADDR;
          end
        end
        S_ADDR_ACK, S_WDATA_ACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= S_WDATA;
        end
        S_RDATA: if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= S_RACK;
          end else begin
            sda_oe <= ~shreg[7];
            shreg  <= {shreg[6:0], 1'b1};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              sda_oe <= ~rd_byte[7];
              shreg  <= {rd_byte[6:0], 1'b1};
              bitcnt <= 4'd1;
              state  <= S_RDATA;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module eeprom_rd_target_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              skip_st,
  input logic [ADDR_W-1:0] ptr
);
  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  assert_foreign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> !sda_oe);
  assert_foreign_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_st && $past(skip_st)) |-> $stable(ptr));
  always_ff @(posedge clk)
    if (!rst_n) assert_reset_release_R10: assert (!sda_oe || $isunknown(sda_oe));
endmodule

bind eeprom_rd_target eeprom_rd_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .skip_st(skip_st), .ptr(ptr)
);

// File: tb/eeprom_rd_target_test.sv
module eeprom_rd_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic init_we = 0;
  logic [6:0] init_addr = '0;
  logic [7:0] init_data = '0;
  logic sda_oe;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit quiet = 0, finished = 0;
  logic [7:0] mem_m [DEPTH];
  int ptr_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_rd_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
  );

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  int mon_errs = 0;
  logic scl_prev = 1, oe_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet && sda_oe) mon_errs++;
      if (sda_oe && !oe_prev && scl) mon_errs++;
    end
    oe_prev = sda_oe;
    scl_prev = scl;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    sda_m = 1; wt(4); scl = 1; wt(8); sda_m = 0; wt(8); scl = 0; wt(4);
  endtask

  task automatic stop_c;
    sda_m = 0; wt(6); scl = 1; wt(8); sda_m = 1; wt(8);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; wt(8); scl = 1; wt(8); scl = 0; wt(4);
  endtask

  task automatic wrbyte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wt(8); scl = 1; wt(4); ack = !sda_bus; wt(4); scl = 0; wt(4);
  endtask

  task automatic rdbyte(bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(8); scl = 1; wt(4); b[i] = sda_bus; wt(4); scl = 0;
    end
    wt(4); sda_m = !mack; wt(4); scl = 1; wt(8); scl = 0; wt(2); sda_m = 1; wt(2);
  endtask

  task automatic cur_read(string req, logic [7:0] ctrl);
    bit a; logic [7:0] d;
    start_c; wrbyte(ctrl, a); chk({req, " ctrl ack"}, 8'(a), 8'd1);
    rdbyte(0, d); stop_c;
    chk(req, d, mem_m[ptr_m]); ptr_m = (ptr_m + 1) % DEPTH;
  endtask

  task automatic rand_read(string req, logic [6:0] addr, int n);
    bit a; logic [7:0] d;
    start_c; wrbyte(8'hA0, a); chk({req, " wctrl ack"}, 8'(a), 8'd1);
    wrbyte({1'b0, addr}, a); chk({req, " addr ack"}, 8'(a), 8'd1);
    ptr_m = addr;
    start_c; wrbyte(8'hA1, a); chk({req, " rctrl ack"}, 8'(a), 8'd1);
    for (int k = 0; k < n; k++) begin
      rdbyte(k != n - 1, d);
      chk(req, d, mem_m[ptr_m]); ptr_m = (ptr_m + 1) % DEPTH;
    end
    stop_c;
  endtask

  initial begin
    bit a;
    wt(3);
    chk("R10 reset release", 8'(sda_oe), 8'd0);
    rst_n = 1; wt(2);
    for (int i = 0; i < DEPTH; i++) begin
      init_we = 1; init_addr = 7'(i); init_data = pattern(i); mem_m[i] = pattern(i); wt(1);
    end
    init_we = 0; wt(4);

    cur_read("R1 R4 R11 read at reset pointer", 8'hA1);
    chk("R6 released after stop", 8'(sda_oe), 8'd0);
    cur_read("R1 R4 don't-care address bits", 8'hAF);
    rand_read("R3 random read", 7'h40, 1);
    rand_read("R5 sequential wrap", 7'h7E, 4);
    cur_read("R4 after wrap", 8'hA1);

    start_c; wrbyte(8'h51, a); chk("R2 foreign code nack", 8'(a), 8'd0);
    quiet = 1; wrbyte(8'h40, a); chk("R2 ignored byte", 8'(a), 8'd0);
    stop_c; quiet = 0;
    cur_read("R2 pointer untouched", 8'hA1);

    start_c; wrbyte(8'hA0, a); chk("R7 wctrl ack", 8'(a), 8'd1);
    wrbyte(8'h10, a); chk("R7 addr ack", 8'(a), 8'd1);
    wrbyte(8'h3C, a); chk("R7 data0 ack", 8'(a), 8'd1);
    wrbyte(8'hC3, a); chk("R7 data1 ack", 8'(a), 8'd1);
    stop_c;
    mem_m[16] = 8'h3C; mem_m[17] = 8'hC3; ptr_m = 18;
    cur_read("R7 pointer past stored bytes", 8'hA1);
    rand_read("R7 stored data", 7'h10, 2);

    start_c; wrbyte(8'hA0, a); chk("R9 wctrl ack", 8'(a), 8'd1);
    for (int i = 0; i < 4; i++) send_bit(1'(i % 2));
    stop_c;
    cur_read("R9 aborted address keeps pointer", 8'hA1);

    checks++;
    if (mon_errs != 0) begin
      errors++;
      $display("FAIL R8 R2 monitor actual %0d expected 0", mon_errs);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule